// File: doc/BRIEF.md
# Synchronous Burst SRAM Data Path

This block is the storage and data side of a synchronous burst SRAM. An address generator outside the block supplies a word address each cycle. On every rising clock edge the block samples the two chip enables, the write controls and the sleep input, and classifies the cycle as a deselect, a read, a write or a sleep cycle. Writes land in the array on the same edge at which address, data and byte selects are sampled. Either chosen bytes or the whole word are written.

Read data reaches the bus in one of two latencies, chosen by a static mode input. In flow-through mode the word read at an edge is on the bus straight after that edge. In pipelined mode it passes through one more output register and appears one edge later. Bus drive is turned off in the cycle right after any non-read command is captured, so a deselect takes effect one stage sooner than a read. The output enable and the sleep input gate the bus drive without waiting for a clock. The bidirectional bus is split into a data input, a data output and a single drive enable.

A four-state command machine records the last captured command. ST_DESEL is entered when either chip enable is low. ST_WRITE is entered when a selected cycle carries a global write, or a byte-write enable with at least one byte select. ST_READ is entered on any other selected cycle. ST_SLEEP is entered whenever sleep is high at the edge, and this takes priority over every other transition. Every state can move to every other state on each edge.

Top module: `sram_datapath`

## Requirements
- R1: With `gwr` low and `bw_en` high, a selected cycle writes only the bytes whose `byte_sel` bit is set (bit b covers data bits 8b+7..8b). With `bw_en` low and `gwr` low, the cycle is a read and changes no byte.
- R2: With `gwr` high, a selected cycle writes all bytes of the word, whatever `bw_en` and `byte_sel` are.
- R3: A cycle is selected only when `ce1` and `ce2` are both high. A cycle that is not selected writes nothing and leaves `d_oe` low after the edge.
- R4: With `pipe_mode` low (flow-through), a read sampled at edge N puts the addressed word on `d_out`, with `d_oe` high, in the cycle after edge N.
- R5: With `pipe_mode` high, a read sampled at edge N is driven in the cycle after edge N+1, and only if edge N+1 also samples a read. `d_oe` stays low after the first read of a run.
- R6: After any edge that samples a write, a deselect or a sleep cycle, `d_oe` is low in the next cycle in both modes.
- R7: `d_oe` follows `oe_in` without waiting for a clock edge. `oe_in` low forces `d_oe` low, and raising it again restores the drive within the same cycle.
- R8: `sleep` high forces `d_oe` low at once. Edges sampled while `sleep` is high accept no write, and the stored words are unchanged after sleep ends.
- R9: A read of an address written at the previous edge returns the newly written data, in both modes.
- R10: After reset, `d_oe` is low until a read has completed its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| ce1 | input | 1 | Chip enable, active high, sampled |
| ce2 | input | 1 | Second chip enable, active high, sampled |
| gwr | input | 1 | Global write, all bytes, sampled |
| bw_en | input | 1 | Byte-write enable, sampled |
| byte_sel | input | NB | Per-byte write selects, sampled |
| pipe_mode | input | 1 | 0 = flow-through read, 1 = pipelined read |
| oe_in | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep request, active high |
| addr | input | AW | Word address from the address generator |
| d_in | input | NB*8 | Write data |
| d_out | output | NB*8 | Read data |
| d_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is a pipelined read whose word is actually driven. It needs a run of at least two back-to-back reads with the mode input held high. A second hard case is a pipelined read of a word written at the edge just before, which needs a write followed straight away by two reads of the same address. The bench builds these runs on successive clock edges and drives no idle cycle in between. It samples on the falling edge after the second read. The asynchronous paths are reached by toggling the output enable and the sleep input in the middle of a cycle while a flow-through read is being driven, and then checking the drive enable before the next edge.

// File: rtl/sram_dp_pkg.sv
`timescale 1ns/1ps
package sram_dp_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } cmd_state_t;
endpackage

// File: rtl/sram_cmd_fsm.sv
`timescale 1ns/1ps
module sram_cmd_fsm
    import sram_dp_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1,
    input  logic          ce2,
    input  logic          gwr,
    input  logic          bw_en,
    input  logic [NB-1:0] byte_sel,
    input  logic          sleep,
    output logic          wr_en,
    output logic          rd_en,
    output logic [NB-1:0] wr_mask,
    output logic          drive_ft,
    output logic          drive_pl
);
    cmd_state_t st_q, st_d;
    logic       prev_rd_q;
    logic       is_write;

    assign is_write = gwr | (bw_en & (|byte_sel));

    // next-state decision: sleep beats everything, then selection, then kind
    always_comb begin
        if (sleep)
            st_d = ST_SLEEP;
        else if (!(ce1 && ce2))
            st_d = ST_DESEL;
        else if (is_write)
            st_d = ST_WRITE;
        else
            st_d = ST_READ;
    end

    assign wr_en   = (st_d == ST_WRITE);
    assign rd_en   = (st_d == ST_READ);
    assign wr_mask = gwr ? {NB{1'b1}} : byte_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_DESEL;
            prev_rd_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            prev_rd_q <= (st_q == ST_READ);
        end
    end

    // outputs from the captured command
    always_comb begin
        drive_ft = 1'b0;
        drive_pl = 1'b0;
        unique case (st_q)
            ST_READ: begin
                drive_ft = 1'b1;
                drive_pl = prev_rd_q;
            end
            ST_DESEL, ST_WRITE, ST_SLEEP: begin
                drive_ft = 1'b0;
                drive_pl = 1'b0;
            end
        endcase
    end

    assert_sleep_enters_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st_q == ST_SLEEP));

    assert_write_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce1 && ce2) |=> (st_q != ST_WRITE));
endmodule

// File: rtl/sram_byte_array.sv
`timescale 1ns/1ps
module sram_byte_array #(
    parameter int AW     = 6,
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [NB-1:0]        wr_mask,
    input  logic [AW-1:0]        addr,
    input  logic [NB*BYTE_W-1:0] wdata,
    output logic [NB*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        logic [BYTE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b])
                mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
            if (rd_en)
                rd_q <= mem[addr];
        end

        assign rdata[b*BYTE_W +: BYTE_W] = rd_q;
    end
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          oe_in,
    input  logic          sleep,
    input  logic          drive_ft,
    input  logic          drive_pl,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] d_out,
    output logic          d_oe
);
    logic [DW-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= rdata;
    end

    assign d_out = pipe_mode ? pipe_q : rdata;
    assign d_oe  = oe_in & ~sleep & (pipe_mode ? drive_pl : drive_ft);
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath #(
    parameter  int AW     = 6,
    parameter  int NB     = 4,
    parameter  int BYTE_W = 8,
    localparam int DW     = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1,
    input  logic          ce2,
    input  logic          gwr,
    input  logic          bw_en,
    input  logic [NB-1:0] byte_sel,
    input  logic          pipe_mode,
    input  logic          oe_in,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe
);
    logic          wr_en, rd_en, drive_ft, drive_pl;
    logic [NB-1:0] wr_mask;
    logic [DW-1:0] rdata;

    sram_cmd_fsm #(.NB(NB)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce1(ce1), .ce2(ce2), .gwr(gwr),
        .bw_en(bw_en), .byte_sel(byte_sel), .sleep(sleep),
        .wr_en(wr_en), .rd_en(rd_en), .wr_mask(wr_mask),
        .drive_ft(drive_ft), .drive_pl(drive_pl)
    );

    sram_byte_array #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .wr_en(wr_en), .rd_en(rd_en), .wr_mask(wr_mask),
        .addr(addr), .wdata(d_in), .rdata(rdata)
    );

    sram_out_stage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_in(oe_in),
        .sleep(sleep), .drive_ft(drive_ft), .drive_pl(drive_pl),
        .rdata(rdata), .d_out(d_out), .d_oe(d_oe)
    );

    assert_ft_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rd_en) |=> (d_oe || !oe_in || sleep || pipe_mode));

    assert_pl_first_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rd_en && !drive_ft) |=> (!d_oe || !pipe_mode));

    assert_nonread_turns_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !d_oe);
endmodule

// File: tb/sram_datapath_bench.sv
`timescale 1ns/1ps
module sram_datapath_bench;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n, ce1, ce2, gwr, bw_en, pipe_mode, oe_in, sleep;
    logic [NB-1:0] byte_sel;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in, d_out;
    logic          d_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [DW-1:0] model [1<<AW];

    sram_datapath #(.AW(AW), .NB(NB), .BYTE_W(8)) u_sram_datapath (
        .clk(clk), .rst_n(rst_n), .ce1(ce1), .ce2(ce2), .gwr(gwr),
        .bw_en(bw_en), .byte_sel(byte_sel), .pipe_mode(pipe_mode),
        .oe_in(oe_in), .sleep(sleep), .addr(addr), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe)
    );

    always #10 clk = ~clk;

    task automatic check_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cmd();
        ce1 = 1'b0; ce2 = 1'b1; gwr = 1'b0; bw_en = 1'b0; byte_sel = '0;
    endtask

    task automatic set_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic g, input logic be, input logic [NB-1:0] s);
        ce1 = 1'b1; ce2 = 1'b1; gwr = g; bw_en = be; byte_sel = s; addr = a; d_in = d;
    endtask

    task automatic set_read(input logic [AW-1:0] a);
        ce1 = 1'b1; ce2 = 1'b1; gwr = 1'b0; bw_en = 1'b0; byte_sel = '0; addr = a;
    endtask

    task automatic ft_read(input logic [AW-1:0] a, input string req);
        pipe_mode = 1'b0;
        set_read(a);
        step();
        check_eq(req, {31'd0, d_oe}, 32'd1);
        check_eq(req, d_out, model[a]);
        idle_cmd();
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check_eq("R10 reset drive", {31'd0, d_oe}, 32'd0);
    endtask

    task automatic t_global_write();
        set_write(6'd5, 32'h11223344, 1'b1, 1'b1, 4'b0001);
        step();
        idle_cmd();
        model[5] = 32'h11223344;
        ft_read(6'd5, "R2 global write");
    endtask

    task automatic t_byte_write();
        set_write(6'd5, 32'hAABBCCDD, 1'b0, 1'b1, 4'b0101);
        step();
        idle_cmd();
        model[5] = 32'h11BB33DD;
        ft_read(6'd5, "R1 byte write lanes 0,2");
        // bw_en low: a read, the word must not change
        pipe_mode = 1'b0;
        set_write(6'd5, 32'h99999999, 1'b0, 1'b0, 4'b1111);
        step();
        check_eq("R1 bw_en low is read", d_out, model[5]);
        idle_cmd();
        step();
    endtask

    task automatic t_deselect_write();
        set_write(6'd5, 32'h55555555, 1'b1, 1'b0, 4'b0000);
        ce2 = 1'b0;
        step();
        check_eq("R3 deselect no drive", {31'd0, d_oe}, 32'd0);
        idle_cmd();
        ft_read(6'd5, "R3 deselected write ignored");
    endtask

    task automatic t_flow_through();
        set_write(6'd10, 32'h0A0A1010, 1'b1, 1'b0, '0); step();
        set_write(6'd11, 32'h0B0B1111, 1'b1, 1'b0, '0); step();
        model[10] = 32'h0A0A1010; model[11] = 32'h0B0B1111;
        pipe_mode = 1'b0;
        set_read(6'd10); step();
        check_eq("R4 ft first word", d_out, model[10]);
        set_read(6'd11); step();
        check_eq("R4 ft second word", d_out, model[11]);
        check_eq("R4 ft drive", {31'd0, d_oe}, 32'd1);
        idle_cmd(); step();
    endtask

    task automatic t_pipelined();
        pipe_mode = 1'b1;
        set_read(6'd10); step();
        check_eq("R5 pl first read quiet", {31'd0, d_oe}, 32'd0);
        set_read(6'd11); step();
        check_eq("R5 pl drive", {31'd0, d_oe}, 32'd1);
        check_eq("R5 pl word A", d_out, model[10]);
        set_read(6'd10); step();
        check_eq("R5 pl word B", d_out, model[11]);
        idle_cmd(); step();
        check_eq("R6 pl deselect turn-off", {31'd0, d_oe}, 32'd0);
        pipe_mode = 1'b0;
        step();
    endtask

    task automatic t_scd_after_write();
        pipe_mode = 1'b0;
        set_read(6'd10); step();
        check_eq("R6 ft read drives", {31'd0, d_oe}, 32'd1);
        set_write(6'd12, 32'h12121212, 1'b1, 1'b0, '0); step();
        model[12] = 32'h12121212;
        check_eq("R6 write turns off", {31'd0, d_oe}, 32'd0);
        idle_cmd(); step();
    endtask

    task automatic t_write_then_read();
        pipe_mode = 1'b0;
        set_write(6'd20, 32'hDEADBEEF, 1'b1, 1'b0, '0); step();
        model[20] = 32'hDEADBEEF;
        set_read(6'd20); step();
        check_eq("R9 ft read after write", d_out, model[20]);
        idle_cmd(); step();
        pipe_mode = 1'b1;
        set_write(6'd21, 32'hCAFEF00D, 1'b1, 1'b0, '0); step();
        model[21] = 32'hCAFEF00D;
        set_read(6'd21); step();
        set_read(6'd21); step();
        check_eq("R9 pl read after write", d_out, model[21]);
        idle_cmd(); step();
        pipe_mode = 1'b0;
        step();
    endtask

    task automatic t_output_enable();
        pipe_mode = 1'b0;
        set_read(6'd11); step();
        check_eq("R7 drive before", {31'd0, d_oe}, 32'd1);
        oe_in = 1'b0; #1;
        check_eq("R7 oe low async", {31'd0, d_oe}, 32'd0);
        oe_in = 1'b1; #1;
        check_eq("R7 oe high async", {31'd0, d_oe}, 32'd1);
        idle_cmd(); step();
    endtask

    task automatic t_sleep();
        pipe_mode = 1'b0;
        set_read(6'd5); step();
        sleep = 1'b1; #1;
        check_eq("R8 sleep async off", {31'd0, d_oe}, 32'd0);
        set_write(6'd5, 32'h77777777, 1'b1, 1'b0, '0);
        step(); step();
        check_eq("R8 sleep no drive", {31'd0, d_oe}, 32'd0);
        sleep = 1'b0;
        idle_cmd(); step();
        ft_read(6'd5, "R8 contents kept");
    endtask

    initial begin
        rst_n = 1'b0; pipe_mode = 1'b0; oe_in = 1'b1; sleep = 1'b0;
        addr = '0; d_in = '0;
        idle_cmd();
        @(negedge clk);
        t_reset();
        t_global_write();
        t_byte_write();
        t_deselect_write();
        t_flow_through();
        t_pipelined();
        t_scd_after_write();
        t_write_then_read();
        t_output_enable();
        t_sleep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1..R10 run: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule